// File: doc/BRIEF.md
# Latched Status and Interrupt Mask

This block gathers the alarm and event flags of a receive-side pattern checker into one host-readable status word. It also drives an interrupt line that a mask word gates. Each status bit belongs to one of three classes. The synchronization bit is live and simply follows its input. Event bits catch single-cycle pulses and hold them until the host reads the status word. Condition bits follow level alarms, and a status read clears them only when the alarm has already gone away.

The host reaches the block through a small register port: one address bit, a read strobe, a write strobe and write data. Read data comes back one cycle after the strobe, flagged by a valid output. Reading the status address returns the word and applies the clear rules in the same cycle. The interrupt output is active-low and registered. It is low whenever any status bit whose mask bit is clear is set.

Top module: `lsim_status_irq`

## Requirements
- R1: Status bit 0 is the live synchronization flag: it equals `sync_i` as sampled at the previous clock edge, including during reset, and a read never changes it.
- R2: Status bits 1 (bit error seen), 2 (bit counter wrapped) and 3 (error counter wrapped) are set by a one-cycle pulse on `evt_i[0]`, `evt_i[1]` and `evt_i[2]` respectively, and stay set until a status read.
- R3: A read strobe with `host_addr_i` = 0 returns, one cycle later on `host_rdata_o` with `host_rvalid_o` high, the status word as it stood before that edge, and clears every event bit that receives no new pulse in that cycle.
- R4: An event pulse arriving in the same cycle as a status read is not in the returned word, but its bit is left set afterwards.
- R5: Status bits 4 (loss of receive signal), 5 and 6 (pattern alarms) are set in every cycle in which `cond_i[0]`, `cond_i[1]` or `cond_i[2]` is high. A status read clears such a bit only if its condition input is low in the cycle of the read.
- R6: `irq_n_o` goes low one cycle after any status bit is set while its mask bit is 0, and returns high one cycle after no such bit remains. A mask bit of 1 keeps its status bit from pulling the interrupt.
- R7: An unmasked condition bit whose condition persists keeps `irq_n_o` low across status reads.
- R8: A write strobe with `host_addr_i` = 0 leaves the status word unchanged.
- R9: The mask word is written with `host_addr_i` = 1 and reads back at that address. Reset sets the mask to all ones and clears status bits 1 to 6, and `irq_n_o` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Live synchronization state |
| evt_i | input | NUM_EVT | One-cycle event pulses |
| cond_i | input | NUM_COND | Level alarm conditions |
| host_addr_i | input | 1 | 0 selects status, 1 selects mask |
| host_rd_i | input | 1 | Read strobe |
| host_wr_i | input | 1 | Write strobe |
| host_wdata_i | input | NUM_EVT+NUM_COND+1 | Write data |
| host_rdata_o | output | NUM_EVT+NUM_COND+1 | Read data, valid one cycle after the strobe |
| host_rvalid_o | output | 1 | Read data valid |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Single event pulses are read twice. The first read shows the latch and the second shows the clear, which tells clear-on-read apart from a live bit. A pulse placed in the very cycle of a read checks that a new event wins over the clear. Condition inputs are held across several reads and then dropped. This separates the conditional clear from the unconditional one. Mask patterns that pass or block a single bit show the interrupt responding to unmasked bits only, and they show a persisting condition holding the line low.

// File: rtl/lsim_pkg.sv
package lsim_pkg;

  typedef enum logic {
    CLS_EVENT = 1'b0,
    CLS_COND  = 1'b1
  } bit_class_e;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

endpackage

// File: rtl/lsim_stat_cell.sv
module lsim_stat_cell #(
  parameter lsim_pkg::bit_class_e CLASS = lsim_pkg::CLS_EVENT
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // A set in the cycle of a clear wins. Event bits see a pulse, condition
  // bits see a level, so one priority gives both clear behaviours.
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  generate
    if (CLASS == lsim_pkg::CLS_EVENT) begin : g_evt
      AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o); // R2
      AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o); // R3
      AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o); // R4
    end else begin : g_cond
      AST_COND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i) |=> q_o); // R5
      AST_COND_DROP: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o); // R5
    end
  endgenerate

endmodule

// File: rtl/lsim_mask_reg.sv
module lsim_mask_reg #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (rst)          mask_o <= '1;
    else if (wr_en_i) mask_o <= wdata_i;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> mask_o == $past(wdata_i)); // R9
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(mask_o)); // R9

endmodule

// File: rtl/lsim_irq_drv.sv
module lsim_irq_drv #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] stat_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_n_o
);

  logic [WIDTH-1:0] pend;
  assign pend = stat_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~(|pend);
  end

endmodule

// File: rtl/lsim_status_irq.sv
module lsim_status_irq #(
  parameter int NUM_EVT  = 3,
  parameter int NUM_COND = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_i,
  input  logic [NUM_EVT-1:0]           evt_i,
  input  logic [NUM_COND-1:0]          cond_i,
  input  logic                         host_addr_i,
  input  logic                         host_rd_i,
  input  logic                         host_wr_i,
  input  logic [NUM_EVT+NUM_COND:0]    host_wdata_i,
  output logic [NUM_EVT+NUM_COND:0]    host_rdata_o,
  output logic                         host_rvalid_o,
  output logic                         irq_n_o
);

  localparam int STAT_W   = NUM_EVT + NUM_COND + 1;
  localparam int EVT_LO   = 1;
  localparam int COND_LO  = EVT_LO + NUM_EVT;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic              stat_rd;
  logic              mask_wr;

  assign stat_rd = host_rd_i && (host_addr_i == lsim_pkg::ADDR_STATUS);
  assign mask_wr = host_wr_i && (host_addr_i == lsim_pkg::ADDR_MASK);

  // Live sync flag: follows its input every cycle, reset does not hold it.
  always_ff @(posedge clk) begin
    stat_q[0] <= sync_i;
  end

  generate
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      lsim_stat_cell #(.CLASS(lsim_pkg::CLS_EVENT)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i[e]),
        .clr_i (stat_rd),
        .q_o   (stat_q[EVT_LO+e])
      );
    end
    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
      lsim_stat_cell #(.CLASS(lsim_pkg::CLS_COND)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (cond_i[c]),
        .clr_i (stat_rd),
        .q_o   (stat_q[COND_LO+c])
      );
    end
  endgenerate

  lsim_mask_reg #(.WIDTH(STAT_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (mask_wr),
    .wdata_i (host_wdata_i),
    .mask_o  (mask_q)
  );

  lsim_irq_drv #(.WIDTH(STAT_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .irq_n_o (irq_n_o)
  );

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid_o <= 1'b0;
      host_rdata_o  <= '0;
    end else begin
      host_rvalid_o <= host_rd_i;
      if (host_rd_i)
        host_rdata_o <= (host_addr_i == lsim_pkg::ADDR_MASK) ? mask_q : stat_q;
    end
  end

  AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> host_rdata_o[0] == $past(sync_i, 2)); // R1
  AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (host_rvalid_o && host_rdata_o == $past(stat_q))); // R3
  AST_WRITE_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (host_wr_i && host_addr_i == lsim_pkg::ADDR_STATUS && !host_rd_i
     && evt_i == '0 && cond_i == '0) |=> stat_q[STAT_W-1:1] == $past(stat_q[STAT_W-1:1])); // R8
  AST_IRQ_PULL: assert property (@(posedge clk) disable iff (rst)
    (stat_q[EVT_LO] && !mask_q[EVT_LO]) |=> !irq_n_o); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~mask_q) == '0) |=> irq_n_o); // R6
  AST_IRQ_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cond_i[0] && stat_q[COND_LO] && !mask_q[COND_LO]) |=> !irq_n_o); // R7

endmodule

// File: tb/lsim_status_irq_bench.sv
module lsim_status_irq_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       sync = 1'b0;
  logic [2:0] evt = '0;
  logic [2:0] cond = '0;
  logic       addr = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [6:0] wdata = '0;
  logic [6:0] rdata;
  logic       rvalid;
  logic       irq_n;

  lsim_status_irq u_lsim_status_irq (
    .clk(clk), .rst(rst), .sync_i(sync), .evt_i(evt), .cond_i(cond),
    .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_rvalid_o(rvalid), .irq_n_o(irq_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic [6:0] mon_exp;
  string      mon_tag;

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: issue a read, queue its expected word; optional pulse alongside.
  task automatic do_read(logic a, logic [6:0] e, string t, logic [2:0] p = 3'b000);
    addr = a; rd = 1'b1; evt = p;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0; evt = '0;
  endtask

  task automatic do_write(logic a, logic [6:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(logic [2:0] p);
    evt = p;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare returned read data against the queue.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3 unexpected read data: actual %h expected none", rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(mon_tag, rdata, mon_exp);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R9 irq high in reset", {6'b0, irq_n}, 7'h01);
    rst = 1'b0;
    idle(1);
    do_read(1'b0, 7'h00, "R9 status reset value");
    do_read(1'b1, 7'h7F, "R9 mask reset value");
    idle(1);
    check("R9 irq high after reset", {6'b0, irq_n}, 7'h01);

    // R1 live sync
    sync = 1'b1; idle(1);
    do_read(1'b0, 7'h01, "R1 sync set");
    do_read(1'b0, 7'h01, "R1 sync not cleared by read");
    sync = 1'b0; idle(1);
    do_read(1'b0, 7'h00, "R1 sync follows low");

    // R2 / R3 single event latch and clear
    pulse(3'b001); idle(5);
    do_read(1'b0, 7'h02, "R2 bit error latched");
    do_read(1'b0, 7'h00, "R3 event cleared by read");
    pulse(3'b110); idle(2);
    do_read(1'b0, 7'h0C, "R2 overflow bits latched");
    do_read(1'b0, 7'h00, "R3 overflow bits cleared");

    // R4 pulse in the read cycle
    do_read(1'b0, 7'h00, "R4 pulse absent from same-cycle read", 3'b010);
    do_read(1'b0, 7'h04, "R4 pulse kept after same-cycle read");
    do_read(1'b0, 7'h00, "R3 cleared afterwards");

    // R5 condition bits
    cond = 3'b001; idle(1);
    do_read(1'b0, 7'h10, "R5 loss of signal set");
    do_read(1'b0, 7'h10, "R5 persisting condition survives read");
    cond = 3'b000; idle(1);
    do_read(1'b0, 7'h10, "R5 latched after condition drops");
    do_read(1'b0, 7'h00, "R5 cleared once condition gone");
    cond = 3'b100; idle(1); cond = 3'b000; idle(1);
    do_read(1'b0, 7'h40, "R5 pattern alarm latched");
    do_read(1'b0, 7'h00, "R5 pattern alarm cleared");

    // R6 interrupt and masking
    do_write(1'b1, 7'h7D);
    pulse(3'b001); idle(1);
    check("R6 unmasked event pulls irq", {6'b0, irq_n}, 7'h00);
    do_read(1'b0, 7'h02, "R6 event read");
    idle(1);
    check("R6 irq released after clear", {6'b0, irq_n}, 7'h01);
    pulse(3'b010); idle(1);
    check("R6 masked event leaves irq high", {6'b0, irq_n}, 7'h01);
    do_read(1'b0, 7'h04, "R6 masked event still latched");
    do_write(1'b1, 7'h7E);
    sync = 1'b1; idle(2);
    check("R6 unmasked sync pulls irq", {6'b0, irq_n}, 7'h00);
    sync = 1'b0; idle(2);
    check("R6 irq follows sync low", {6'b0, irq_n}, 7'h01);

    // R7 persisting condition holds irq
    do_write(1'b1, 7'h6F);
    cond = 3'b001; idle(2);
    check("R7 condition pulls irq", {6'b0, irq_n}, 7'h00);
    do_read(1'b0, 7'h10, "R7 condition read");
    idle(1);
    check("R7 irq held across read", {6'b0, irq_n}, 7'h00);
    cond = 3'b000; idle(1);
    do_read(1'b0, 7'h10, "R7 last read of condition");
    idle(1);
    check("R7 irq released after condition gone", {6'b0, irq_n}, 7'h01);

    // R8 write to status ignored
    do_write(1'b0, 7'h7F); idle(1);
    do_read(1'b0, 7'h00, "R8 status write ignored");
    check("R8 irq unaffected by status write", {6'b0, irq_n}, 7'h01);

    // R9 mask readback
    do_write(1'b1, 7'h55);
    do_read(1'b1, 7'h55, "R9 mask readback");
    do_read(1'b0, 7'h00, "R9 mask write leaves status");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule